// File: doc/BRIEF.md
# Scanline-Counting Interrupt Generator

This block lets a CPU request an interrupt a set number of video scanlines ahead. Software writes an 8-bit reload value and can force a reload, then arms the interrupt. The block watches the video timing inputs and produces one counter tick per rendered scanline, at a fixed dot position within the line. The counter is a down-counter that reloads itself when it is found at zero. When a tick leaves it at zero and the interrupt is armed, a level interrupt is raised and stays raised until the CPU acknowledges it.

The register port decodes address bits [15:13] and bit 0. Bits [15:13] = 3'b110 select the reload pair and 3'b111 select the arm pair. Within each pair, an even address and an odd address act differently. Bank mapping and the picture pipeline are outside this block.

Top module: `scanline_irq_top`

## Requirements
- R1: After a synchronous active-low reset, `irq_out` is 0, the counter and reload value are 0, and the interrupt is disarmed.
- R2: A write with `wr_addr[15:13]` = 3'b110 and `wr_addr[0]` = 0 stores `wr_data` as the reload value.
- R3: A write with `wr_addr[15:13]` = 3'b110 and `wr_addr[0]` = 1 forces the counter to 0, so the next tick loads the reload value. This write takes precedence over a tick in the same cycle.
- R4: On a tick, a counter at 0 takes the reload value and any other count decrements by one. If the new count is 0 and the interrupt was armed before that cycle's writes, the pending flag is set, and `irq_out` shows it one cycle later.
- R5: A write with `wr_addr[15:13]` = 3'b111 and `wr_addr[0]` = 0 disarms the interrupt and clears any pending interrupt. The same region with `wr_addr[0]` = 1 arms it.
- R6: A pending interrupt holds `irq_out` high until `irq_ack` is seen. An acknowledge clears it, unless a new interrupt is raised in the same cycle.
- R7: A tick occurs only while `render_on` is 1, in one of three cases. With `tall_sprites` = 1, it occurs at line cycle 260. With 8-pixel sprites, `bg_table_hi` = 0 and `spr_table_hi` = 1, it occurs at line cycle 260. With 8-pixel sprites, `bg_table_hi` = 1 and `spr_table_hi` = 0, it occurs at line cycle 324. Any other setting produces no tick.
- R8: A qualifying condition held over several clocks produces only one tick. Another tick needs the condition to drop and return.
- R9: With a reload value of 0 and the interrupt armed, every tick raises an interrupt.
- R10: Writes with `wr_addr[15:14]` other than 2'b11 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line_cycle | input | 9 | Current dot position within the scanline |
| render_on | input | 1 | Rendering active |
| tall_sprites | input | 1 | 1 = 16-pixel sprites, 0 = 8-pixel |
| bg_table_hi | input | 1 | Background uses the upper pattern table |
| spr_table_hi | input | 1 | Sprites use the upper pattern table |
| irq_ack | input | 1 | CPU has taken the interrupt |
| irq_out | output | 1 | Level interrupt request |

## Verification
The assertions check the following on every cycle:
- a tick only happens while rendering, at cycle 260 or 324;
- a tick is never generated in two consecutive cycles;
- the counter reads zero after a forced reload;
- a tick on a nonzero count decrements it by one;
- a disarm write always drops the interrupt line;
- a raised line holds until it is acknowledged or disarmed.

Only the bench scenarios can show the end-to-end count. They show that the interrupt arrives on the tick after the reload value has run down, and not earlier. They also show that each pattern-table setting picks the correct tick point, and that writes outside the register window leave the reload value intact.

// File: rtl/scanirq_pkg.sv
// Package: shared types for the scanline interrupt generator.
// Assumes one write command is decoded per cycle at most.
package scanirq_pkg;

    // Decoded register action for one CPU write
    typedef struct packed {
        logic set_latch;   // store reload value
        logic clr_count;   // force counter to zero
        logic irq_off;     // disarm and drop pending
        logic irq_on;      // arm
    } scanirq_cmd_t;

endpackage

// File: rtl/scanirq_decode.sv
// Module: scanirq_decode
// Turns a CPU write into one register action. Bits [top:top-2] select
// the region (110 reload pair, 111 arm pair); bit 0 picks even/odd.
// Assumes wr_en is a single-cycle strobe. Purely combinational.
module scanirq_decode
    import scanirq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output scanirq_cmd_t      cmd
);
    localparam logic [2:0] RGN_RELOAD = 3'b110;
    localparam logic [2:0] RGN_ARM    = 3'b111;

    logic [2:0] region;
    logic       odd;

    assign region = wr_addr[ADDR_W-1 -: 3];
    assign odd    = wr_addr[0];

    // Map region and address parity to one action
    always_comb begin
        cmd = '0;
        if (wr_en) begin
            if (region == RGN_RELOAD) begin
                cmd.set_latch = !odd;
                cmd.clr_count = odd;
            end else if (region == RGN_ARM) begin
                cmd.irq_off = !odd;
                cmd.irq_on  = odd;
            end
        end
    end
endmodule

// File: rtl/scanirq_tick.sv
// Module: scanirq_tick
// Produces a one-cycle tick when the scanline qualifier becomes true.
// The qualifier picks cycle CYC_NEAR or CYC_FAR from the sprite height
// and the pattern-table setting, and is only valid while rendering.
// Assumes the timing inputs are synchronous to clk.
module scanirq_tick #(
    parameter int CYC_W    = 9,
    parameter int CYC_NEAR = 260,
    parameter int CYC_FAR  = 324
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CYC_W-1:0] line_cycle,
    input  logic             render_on,
    input  logic             tall_sprites,
    input  logic             bg_table_hi,
    input  logic             spr_table_hi,
    output logic             tick
);
    localparam logic [CYC_W-1:0] NEAR_C = CYC_W'(CYC_NEAR);
    localparam logic [CYC_W-1:0] FAR_C  = CYC_W'(CYC_FAR);

    logic at_near, at_far, use_near, use_far, qual, qual_q;

    assign at_near  = (line_cycle == NEAR_C);
    assign at_far   = (line_cycle == FAR_C);

    // Select which dot position qualifies for this table setup
    always_comb begin
        use_near = tall_sprites || (!bg_table_hi && spr_table_hi);
        use_far  = !tall_sprites && bg_table_hi && !spr_table_hi;
    end

    assign qual = render_on && ((use_near && at_near) || (use_far && at_far));

    // Remember last qualifier so a held condition ticks only once
    always_ff @(posedge clk) begin
        if (!rst_n) qual_q <= 1'b0;
        else        qual_q <= qual;
    end

    assign tick = qual && !qual_q;
endmodule

// File: rtl/scanirq_count.sv
// Module: scanirq_count
// Holds the reload value, the down-counter, the arm bit and the pending
// flag. A forced reload beats a tick; a disarm beats a new interrupt,
// and a new interrupt beats an acknowledge. Arm state used for raising
// is the value before this cycle's write.
module scanirq_count
    import scanirq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  scanirq_cmd_t      cmd,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tick,
    input  logic              irq_ack,
    output logic [DATA_W-1:0] count,
    output logic              irq
);
    logic [DATA_W-1:0] latch_q, cnt_q, cnt_nxt;
    logic              armed_q, pend_q, raise;

    // Next counter value from forced reload or tick
    always_comb begin
        cnt_nxt = cnt_q;
        if (cmd.clr_count)
            cnt_nxt = '0;
        else if (tick)
            cnt_nxt = (cnt_q == '0) ? latch_q : cnt_q - DATA_W'(1);
    end

    assign raise = tick && !cmd.clr_count && armed_q && (cnt_nxt == '0);

    // Register update for reload value, counter, arm and pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            cnt_q   <= '0;
            armed_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            if (cmd.set_latch) latch_q <= wr_data;
            cnt_q <= cnt_nxt;
            if (cmd.irq_off)     armed_q <= 1'b0;
            else if (cmd.irq_on) armed_q <= 1'b1;
            if (cmd.irq_off)     pend_q <= 1'b0;
            else if (raise)      pend_q <= 1'b1;
            else if (irq_ack)    pend_q <= 1'b0;
        end
    end

    assign count = cnt_q;
    assign irq   = pend_q;
endmodule

// File: rtl/scanline_irq_top.sv
// Module: scanline_irq_top
// Scanline-counting interrupt generator: decodes CPU writes, derives a
// per-scanline tick from video timing, and runs the reload counter.
// Assumes all inputs are synchronous to clk; reset is synchronous, low.
module scanline_irq_top
    import scanirq_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int CYC_W    = 9,
    parameter int CYC_NEAR = 260,
    parameter int CYC_FAR  = 324
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CYC_W-1:0]  line_cycle,
    input  logic              render_on,
    input  logic              tall_sprites,
    input  logic              bg_table_hi,
    input  logic              spr_table_hi,
    input  logic              irq_ack,
    output logic              irq_out
);
    scanirq_cmd_t      cmd_w;
    logic              tick_w;
    logic [DATA_W-1:0] cnt_w;

    scanirq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .cmd     (cmd_w)
    );

    scanirq_tick #(.CYC_W(CYC_W), .CYC_NEAR(CYC_NEAR), .CYC_FAR(CYC_FAR)) u_tick (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_cycle   (line_cycle),
        .render_on    (render_on),
        .tall_sprites (tall_sprites),
        .bg_table_hi  (bg_table_hi),
        .spr_table_hi (spr_table_hi),
        .tick         (tick_w)
    );

    scanirq_count #(.DATA_W(DATA_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd_w),
        .wr_data (wr_data),
        .tick    (tick_w),
        .irq_ack (irq_ack),
        .count   (cnt_w),
        .irq     (irq_out)
    );
endmodule

// File: rtl/scanirq_chk.sv
// Module: scanirq_chk
// Property checker bound into scanline_irq_top. Observes ports plus the
// tick and counter nets that separate the sub-blocks.
module scanirq_chk #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int CYC_W    = 9,
    parameter int CYC_NEAR = 260,
    parameter int CYC_FAR  = 324
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CYC_W-1:0]  line_cycle,
    input logic              render_on,
    input logic              irq_ack,
    input logic              irq_out,
    input logic              tick,
    input logic [DATA_W-1:0] cnt
);
    logic wr_reload, wr_off;
    assign wr_reload = wr_en && (wr_addr[ADDR_W-1 -: 3] == 3'b110) && wr_addr[0];
    assign wr_off    = wr_en && (wr_addr[ADDR_W-1 -: 3] == 3'b111) && !wr_addr[0];

    // R7: ticks only while rendering at one of the two dot positions
    p_tick_point_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (render_on && (line_cycle == CYC_W'(CYC_NEAR) || line_cycle == CYC_W'(CYC_FAR))));

    // R8: never two ticks back to back
    p_single_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R3: forced reload leaves the counter at zero
    p_reload_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reload |=> (cnt == '0));

    // R4: a tick on a nonzero count decrements it
    p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_reload && cnt != '0) |=> (cnt == $past(cnt) - DATA_W'(1)));

    // R5: disarm always drops the line
    p_disarm_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_off |=> !irq_out);

    // R6: raised line holds until acknowledged or disarmed
    p_irq_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !irq_ack && !wr_off) |=> irq_out);
endmodule

bind scanline_irq_top scanirq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYC_W(CYC_W),
    .CYC_NEAR(CYC_NEAR), .CYC_FAR(CYC_FAR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .line_cycle (line_cycle),
    .render_on  (render_on),
    .irq_ack    (irq_ack),
    .irq_out    (irq_out),
    .tick       (tick_w),
    .cnt        (cnt_w)
);

// File: tb/tb_scanline_irq_top.sv
`timescale 1ns/1ps
module tb_scanline_irq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [8:0]  line_cycle = '0;
    logic        render_on = 1'b0, tall_sprites = 1'b0;
    logic        bg_table_hi = 1'b0, spr_table_hi = 1'b0;
    logic        irq_ack = 1'b0;
    logic        irq_out;

    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    scanline_irq_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .line_cycle(line_cycle), .render_on(render_on),
        .tall_sprites(tall_sprites), .bg_table_hi(bg_table_hi),
        .spr_table_hi(spr_table_hi), .irq_ack(irq_ack), .irq_out(irq_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model, compared after every clock
    int  m_latch = 0, m_cnt = 0, m_nxt = 0;
    bit  m_arm = 0, m_pend = 0, m_prev = 0, m_q = 0, m_tk = 0, m_raise = 0;
    bit  w_lat = 0, w_clr = 0, w_off = 0, w_on = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_latch = 0; m_cnt = 0; m_arm = 0; m_pend = 0; m_prev = 0;
        end else begin
            m_q = render_on && ((tall_sprites && line_cycle == 260) ||
                  (!tall_sprites && !bg_table_hi && spr_table_hi && line_cycle == 260) ||
                  (!tall_sprites && bg_table_hi && !spr_table_hi && line_cycle == 324));
            m_tk = m_q && !m_prev;
            m_prev = m_q;
            w_lat = wr_en && wr_addr[15:13] == 3'b110 && !wr_addr[0];
            w_clr = wr_en && wr_addr[15:13] == 3'b110 && wr_addr[0];
            w_off = wr_en && wr_addr[15:13] == 3'b111 && !wr_addr[0];
            w_on  = wr_en && wr_addr[15:13] == 3'b111 && wr_addr[0];
            m_nxt = m_cnt;
            if (w_clr) m_nxt = 0;
            else if (m_tk) m_nxt = (m_cnt == 0) ? m_latch : m_cnt - 1;
            m_raise = m_tk && !w_clr && m_arm && m_nxt == 0;
            m_cnt = m_nxt;
            if (w_lat) m_latch = wr_data;
            if (w_off) m_pend = 0;
            else if (m_raise) m_pend = 1;
            else if (irq_ack) m_pend = 0;
            if (w_off) m_arm = 0;
            else if (w_on) m_arm = 1;
        end
        #1;
        chk(irq_out == m_pend, "R4 model", irq_out, m_pend);
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1;
        @(negedge clk); irq_ack = 0;
    endtask

    task automatic setv(input bit tl, input bit bh, input bit sh, input bit rn);
        @(negedge clk);
        tall_sprites = tl; bg_table_hi = bh; spr_table_hi = sh; render_on = rn;
    endtask

    // Step line_cycle from a to b, one dot per clock, then idle
    task automatic run(input int a, input int b);
        for (int c = a; c <= b; c++) begin
            @(negedge clk); line_cycle = 9'(c);
        end
        @(negedge clk); line_cycle = '0;
    endtask

    task automatic line();
        run(250, 330);
    endtask

    task automatic hold(input int c, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); line_cycle = 9'(c);
        end
        @(negedge clk); line_cycle = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(irq_out == 0, "R1 reset", irq_out, 0);
        rst_n = 1;
        @(negedge clk);
        chk(irq_out == 0, "R1 after reset", irq_out, 0);

        // R2/R3/R4: reload 2 then count down
        wr(16'hC000, 8'd2);
        wr(16'hC001, 8'd0);
        wr(16'hE001, 8'd0);
        setv(0, 0, 1, 1);
        line(); chk(irq_out == 0, "R3 reload tick", irq_out, 0);
        line(); chk(irq_out == 0, "R4 count 1", irq_out, 0);
        line(); chk(irq_out == 1, "R2 R4 reaches zero", irq_out, 1);

        // R6: holds without ack, ack clears
        line(); chk(irq_out == 1, "R6 held", irq_out, 1);
        ack();  chk(irq_out == 0, "R6 ack", irq_out, 0);

        // R5: disarm clears pending and blocks raising
        line(); line(); chk(irq_out == 1, "R5 pre", irq_out, 1);
        wr(16'hE000, 8'd0); chk(irq_out == 0, "R5 disarm clears", irq_out, 0);
        line(); line(); line(); chk(irq_out == 0, "R5 disarmed", irq_out, 0);

        // R9: zero reload raises on every tick
        wr(16'hC000, 8'd0); wr(16'hE001, 8'd0); wr(16'hC001, 8'd0);
        line(); chk(irq_out == 1, "R9 first", irq_out, 1);
        ack();
        line(); chk(irq_out == 1, "R9 second", irq_out, 1);
        ack();

        // R7: tick point selection
        setv(0, 0, 1, 0);
        line(); chk(irq_out == 0, "R7 render off", irq_out, 0);
        setv(0, 0, 0, 1);
        line(); chk(irq_out == 0, "R7 both tables low", irq_out, 0);
        setv(0, 0, 1, 1);
        run(250, 300); chk(irq_out == 1, "R7 near point", irq_out, 1);
        ack();
        setv(0, 1, 0, 1);
        run(250, 300); chk(irq_out == 0, "R7 far not yet", irq_out, 0);
        run(301, 330); chk(irq_out == 1, "R7 far point", irq_out, 1);
        ack();
        setv(1, 1, 0, 1);
        run(250, 300); chk(irq_out == 1, "R7 tall sprites", irq_out, 1);
        ack();

        // R8: held qualifier gives one tick
        setv(0, 0, 1, 1);
        wr(16'hC000, 8'd1); wr(16'hC001, 8'd0);
        hold(260, 6); chk(irq_out == 0, "R8 held once", irq_out, 0);
        hold(260, 3); chk(irq_out == 1, "R8 second run", irq_out, 1);
        ack();

        // R10: out-of-window writes leave reload value at 1
        wr(16'h8000, 8'd0); wr(16'h8001, 8'd0); wr(16'h6000, 8'd0);
        wr(16'hA000, 8'd0); wr(16'h4001, 8'd0);
        line(); chk(irq_out == 0, "R10 reload kept", irq_out, 0);
        line(); chk(irq_out == 1, "R10 counted", irq_out, 1);

        repeat (4) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule